// File: doc/BRIEF.md
# Multiplexed SAR ADC Control Sequencer

This block drives an external eight-input, 8-bit successive-approximation converter through one complete conversion per request. A client raises `req` for one cycle with a 3-bit input number while the block is idle. The sequencer places that number on the converter's address lines and pulses the address-latch enable. It then gives the start line a full high-then-low pulse, because the converter clears its approximation register on the rising edge and begins converting on the falling edge.

After the start pulse the sequencer runs a two-phase handshake on the end-of-conversion line. That line is first re-timed by a two-flop synchronizer. The sequencer waits for the line to drop, which confirms that a conversion is running, and then for it to come back high, which marks completion. It then raises output enable for a configurable number of cycles and captures the data bus in the last of them. Finally it presents the 8-bit code and its input number with a one-cycle valid strobe. If either wait phase runs longer than a programmable limit, the block drops the attempt, pulses an error flag and returns to idle without a valid strobe.

The block also produces the converter's clock by dividing the system clock. With the defaults, a 200 MHz system clock gives 500 kHz, which is below the converter's 640 kHz ceiling. A nominal conversion at that rate lasts about 130 µs, and the default wait limit is about twice that. Each code step is one 255th of the reference span.

Top module: `adc_seq_ctrl`

## Requirements
- R1: While reset is high and whenever the block is idle, `adc_ale`, `adc_start`, `adc_oe`, `busy`, `res_valid` and `err_timeout` are all low.
- R2: `adc_clk` is low after reset and toggles every `DIV_HALF` system cycles, giving a period of 2·`DIV_HALF` cycles.
- R3: An idle `req` is accepted at the clock edge where it is seen. From the next cycle `adc_addr` equals `req_chan`, `adc_ale` is high for exactly 2·`DIV_HALF` cycles, and `adc_addr` does not change while `adc_ale` is high.
- R4: `adc_start` rises in the cycle in which `adc_ale` falls and stays high for exactly 2·`DIV_HALF` cycles. `adc_ale`, `adc_start` and `adc_oe` are never high together, and no two of them are high at once.
- R5: `adc_oe` rises only after `adc_eoc` has been low and then high again since the most recent start pulse.
- R6: `adc_oe` stays high for exactly `OE_CYCLES` cycles. In the cycle after it falls, `res_valid` is high for one cycle, with `res_data` equal to the bus value sampled while `adc_oe` was high and `res_chan` equal to the accepted channel.
- R7: If `adc_eoc` fails to fall, or fails to rise again, within `TIMEOUT_CYC` cycles of the end of the start pulse, `err_timeout` pulses for one cycle, `busy` drops in that same cycle, and no `res_valid` is produced for that request.
- R8: A `req` seen while `busy` is high is discarded. It does not change `adc_addr`, it produces no result, and it is not replayed once the block is idle.
- R9: `busy` is high from the cycle after acceptance until the block is idle again. `res_valid` and `err_timeout` are never high together, and `busy` is low in the cycle after `res_valid`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| req | input | 1 | Conversion request, one cycle |
| req_chan | input | 3 | Analog input to convert |
| busy | output | 1 | Conversion sequence in progress |
| res_valid | output | 1 | One-cycle result strobe |
| res_data | output | 8 | Captured conversion code |
| res_chan | output | 3 | Input number that goes with `res_data` |
| err_timeout | output | 1 | One-cycle flag: conversion wait timed out |
| adc_clk | output | 1 | Divided clock for the converter |
| adc_addr | output | 3 | Converter input-select address |
| adc_ale | output | 1 | Address latch enable, active high |
| adc_start | output | 1 | Conversion start pulse, active high |
| adc_oe | output | 1 | Converter output enable, active high |
| adc_eoc | input | 1 | End of conversion from converter (asynchronous) |
| adc_data | input | 8 | Converter data bus |

## Verification
The assertions check these rules on every cycle:
- strobes stay low while idle;
- the three converter strobes are mutually exclusive;
- the address holds during the latch pulse;
- the valid and error pulses last one cycle and never coincide;
- a valid is always preceded by output enable;
- the block is idle after each result.

The bench's scenarios cover the rest, using a behavioural converter model. They show:
- exact strobe lengths and the divider period;
- that output enable waits for the full low-then-high end-of-conversion sequence;
- that the captured code matches the addressed input under two data patterns;
- that a request arriving mid-conversion leaves no trace;
- that both stuck-line faults (line never falls, line never rises) end in a timely error without a result.

// File: rtl/adc_seq_pkg.sv
package adc_seq_pkg;

    localparam int CHAN_W = 3;
    localparam int CODE_W = 8;

    typedef enum logic [2:0] {
        SQ_IDLE,
        SQ_LATCH,
        SQ_START_HI,
        SQ_START_LO,
        SQ_WAIT_LO,
        SQ_WAIT_HI,
        SQ_READ,
        SQ_DONE
    } seq_state_t;

    typedef struct packed {
        logic [CHAN_W-1:0] chan;
        logic [CODE_W-1:0] code;
    } sample_t;

    function automatic int max3(input int a, input int b, input int c);
        int m;
        m = (a > b) ? a : b;
        return (m > c) ? m : c;
    endfunction

    function automatic logic in_wait(input seq_state_t s);
        return (s == SQ_WAIT_LO) || (s == SQ_WAIT_HI);
    endfunction

endpackage

// File: rtl/adc_clk_div.sv
module adc_clk_div #(
    parameter int HALF = 200
) (
    input  logic clk,
    input  logic rst,
    output logic clk_o
);
    localparam int W = $clog2(HALF + 1);
    localparam logic [W-1:0] LAST = W'(HALF - 1);

    logic [W-1:0] cnt;

    always_ff @(posedge clk) begin
        if (rst) begin
            cnt   <= '0;
            clk_o <= 1'b0;
        end else if (cnt == LAST) begin
            cnt   <= '0;
            clk_o <= ~clk_o;
        end else begin
            cnt <= cnt + 1'b1;
        end
    end
endmodule

// File: rtl/adc_sync2.sv
module adc_sync2 #(
    parameter int             W       = 1,
    parameter logic [W-1:0]   RST_VAL = '1
) (
    input  logic         clk,
    input  logic         rst,
    input  logic [W-1:0] d,
    output logic [W-1:0] q
);
    logic [W-1:0] meta;

    always_ff @(posedge clk) begin
        if (rst) begin
            meta <= RST_VAL;
            q    <= RST_VAL;
        end else begin
            meta <= d;
            q    <= meta;
        end
    end
endmodule

// File: rtl/adc_step_cnt.sv
module adc_step_cnt #(
    parameter int W = 8
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         clr,
    input  logic         en,
    output logic [W-1:0] cnt
);
    always_ff @(posedge clk) begin
        if (rst || clr) begin
            cnt <= '0;
        end else if (en) begin
            cnt <= cnt + 1'b1;
        end
    end
endmodule

// File: rtl/adc_seq_ctrl.sv
module adc_seq_ctrl
    import adc_seq_pkg::*;
#(
    parameter int DIV_HALF    = 200,
    parameter int TIMEOUT_CYC = 52000,
    parameter int OE_CYCLES   = 4
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              req,
    input  logic [CHAN_W-1:0] req_chan,
    output logic              busy,
    output logic              res_valid,
    output logic [CODE_W-1:0] res_data,
    output logic [CHAN_W-1:0] res_chan,
    output logic              err_timeout,
    output logic              adc_clk,
    output logic [CHAN_W-1:0] adc_addr,
    output logic              adc_ale,
    output logic              adc_start,
    output logic              adc_oe,
    input  logic              adc_eoc,
    input  logic [CODE_W-1:0] adc_data
);
    localparam int STROBE = 2 * DIV_HALF;
    localparam int CNT_W  = $clog2(max3(STROBE, TIMEOUT_CYC, OE_CYCLES) + 1);
    localparam logic [CNT_W-1:0] STROBE_LAST = CNT_W'(STROBE - 1);
    localparam logic [CNT_W-1:0] TO_LAST     = CNT_W'(TIMEOUT_CYC - 1);
    localparam logic [CNT_W-1:0] OE_LAST     = CNT_W'(OE_CYCLES - 1);

    seq_state_t        state, nxt;
    logic [CNT_W-1:0]  cnt;
    logic              cnt_clr, err_set, capture, eoc_s;
    logic [CHAN_W-1:0] chan_q;
    sample_t           res_q;
    logic              err_q;

    adc_clk_div #(.HALF(DIV_HALF)) u_div (
        .clk(clk), .rst(rst), .clk_o(adc_clk)
    );

    adc_sync2 #(.W(1), .RST_VAL(1'b1)) u_eoc_sync (
        .clk(clk), .rst(rst), .d(adc_eoc), .q(eoc_s)
    );

    adc_step_cnt #(.W(CNT_W)) u_cnt (
        .clk(clk), .rst(rst), .clr(cnt_clr),
        .en(state != SQ_IDLE), .cnt(cnt)
    );

    always_comb begin
        nxt     = state;
        cnt_clr = 1'b0;
        err_set = 1'b0;
        capture = 1'b0;
        unique case (state)
            SQ_IDLE: if (req) begin
                nxt = SQ_LATCH; cnt_clr = 1'b1;
            end
            SQ_LATCH: if (cnt == STROBE_LAST) begin
                nxt = SQ_START_HI; cnt_clr = 1'b1;
            end
            SQ_START_HI: if (cnt == STROBE_LAST) begin
                nxt = SQ_START_LO; cnt_clr = 1'b1;
            end
            SQ_START_LO: if (cnt == STROBE_LAST) begin
                nxt = SQ_WAIT_LO; cnt_clr = 1'b1;
            end
            SQ_WAIT_LO: begin
                if (!eoc_s) begin
                    nxt = SQ_WAIT_HI;
                end else if (cnt == TO_LAST) begin
                    nxt = SQ_IDLE; err_set = 1'b1;
                end
            end
            SQ_WAIT_HI: begin
                if (eoc_s) begin
                    nxt = SQ_READ; cnt_clr = 1'b1;
                end else if (cnt == TO_LAST) begin
                    nxt = SQ_IDLE; err_set = 1'b1;
                end
            end
            SQ_READ: if (cnt == OE_LAST) begin
                nxt = SQ_DONE; capture = 1'b1;
            end
            SQ_DONE: nxt = SQ_IDLE;
            default: nxt = SQ_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            state  <= SQ_IDLE;
            chan_q <= '0;
            res_q  <= '0;
            err_q  <= 1'b0;
        end else begin
            state <= nxt;
            err_q <= err_set;
            if (state == SQ_IDLE && req) chan_q <= req_chan;
            if (capture) begin
                res_q.chan <= chan_q;
                res_q.code <= adc_data;
            end
        end
    end

    assign busy        = (state != SQ_IDLE);
    assign adc_addr    = chan_q;
    assign adc_ale     = (state == SQ_LATCH);
    assign adc_start   = (state == SQ_START_HI);
    assign adc_oe      = (state == SQ_READ);
    assign res_valid   = (state == SQ_DONE);
    assign res_data    = res_q.code;
    assign res_chan    = res_q.chan;
    assign err_timeout = err_q;
endmodule

// File: rtl/adc_seq_checker.sv
module adc_seq_checker
    import adc_seq_pkg::*;
(
    input logic              clk,
    input logic              rst,
    input logic              busy,
    input logic              ale,
    input logic              start,
    input logic              oe,
    input logic [CHAN_W-1:0] addr,
    input logic              valid,
    input logic              err
);
    p_idle_quiet_r1: assert property (@(posedge clk) disable iff (rst)
        !busy |-> (!ale && !start && !oe && !valid));

    p_addr_hold_r3: assert property (@(posedge clk) disable iff (rst)
        (ale && $past(ale)) |-> $stable(addr));

    p_strobe_excl_r4: assert property (@(posedge clk) disable iff (rst)
        $countones({ale, start, oe}) <= 1);

    p_valid_one_r6: assert property (@(posedge clk) disable iff (rst)
        valid |=> !valid);

    p_oe_then_valid_r6: assert property (@(posedge clk) disable iff (rst)
        valid |-> $past(oe));

    p_err_one_r7: assert property (@(posedge clk) disable iff (rst)
        err |=> !err);

    p_err_idle_r7: assert property (@(posedge clk) disable iff (rst)
        err |-> !busy);

    p_no_both_r9: assert property (@(posedge clk) disable iff (rst)
        !(valid && err));

    p_idle_after_r9: assert property (@(posedge clk) disable iff (rst)
        valid |=> !busy);
endmodule

bind adc_seq_ctrl adc_seq_checker u_chk (
    .clk(clk), .rst(rst), .busy(busy), .ale(adc_ale), .start(adc_start),
    .oe(adc_oe), .addr(adc_addr), .valid(res_valid), .err(err_timeout)
);

// File: tb/sim_adc_seq_ctrl.sv
module sim_adc_seq_ctrl;
    import adc_seq_pkg::*;

    localparam int DIV_HALF = 2;
    localparam int TIMEOUT  = 300;
    localparam int OE_CYC   = 3;
    localparam int STROBE   = 2 * DIV_HALF;
    localparam int CONV     = 100;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic req = 1'b0;
    logic [CHAN_W-1:0] req_chan = '0;
    logic busy, res_valid, err_timeout, adc_clk, adc_ale, adc_start, adc_oe;
    logic [CODE_W-1:0] res_data, adc_data;
    logic [CHAN_W-1:0] res_chan, adc_addr;
    logic eoc_pin = 1'b1;

    int checks = 0;
    int fails  = 0;
    bit finished = 1'b0;

    int mode = 0;                     // 0 normal, 1 stuck high, 2 stuck low
    logic [CODE_W-1:0] pat = 8'h5A;
    logic [CHAN_W-1:0] lat_addr = '0;
    sample_t exp_q[$];

    always #2.5 clk = ~clk;

    function automatic logic [CODE_W-1:0] code_of(input logic [CHAN_W-1:0] c,
                                                  input logic [CODE_W-1:0] p);
        return (CODE_W'(c) * 8'h11) ^ p;
    endfunction

    assign adc_data = adc_oe ? code_of(lat_addr, pat) : 8'h00;

    adc_seq_ctrl #(.DIV_HALF(DIV_HALF), .TIMEOUT_CYC(TIMEOUT), .OE_CYCLES(OE_CYC)) u0 (
        .clk(clk), .rst(rst), .req(req), .req_chan(req_chan), .busy(busy),
        .res_valid(res_valid), .res_data(res_data), .res_chan(res_chan),
        .err_timeout(err_timeout), .adc_clk(adc_clk), .adc_addr(adc_addr),
        .adc_ale(adc_ale), .adc_start(adc_start), .adc_oe(adc_oe),
        .adc_eoc(eoc_pin), .adc_data(adc_data)
    );

    task automatic chk(input bit ok, input string rq, input int act, input int exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s: actual %0d expected %0d", rq, act, exp);
        end
    endtask

    // Converter model and monitors share one process to keep ordering fixed.
    int  phase = 0, pc = 0;
    int  ale_run = 0, st_run = 0, oe_run = 0, clk_gap = 0, clk_chk = 0;
    bit  st_prev = 0, ale_prev = 0, oe_prev = 0, clk_prev = 0, saw_low = 0, clk_seen = 0;

    always @(negedge clk) begin
        if (!rst) begin
            // converter model
            if (adc_ale) lat_addr = adc_addr;
            if (adc_start) saw_low = 0;
            case (phase)
                0: if (st_prev && !adc_start) begin phase = 1; pc = 0; end
                1: begin
                    pc++;
                    if (pc == 3) begin
                        if (mode != 1) eoc_pin = 1'b0;
                        phase = 2; pc = 0;
                    end
                end
                default: begin
                    pc++;
                    if (pc == CONV) begin
                        if (mode == 0) eoc_pin = 1'b1;
                        phase = 0;
                    end
                end
            endcase
            if (!eoc_pin) saw_low = 1;

            // R2: divider period
            clk_gap++;
            if (adc_clk != clk_prev) begin
                if (clk_seen && clk_chk < 8) begin
                    chk(clk_gap == DIV_HALF, "R2 adc_clk half period", clk_gap, DIV_HALF);
                    clk_chk++;
                end
                clk_seen = 1; clk_gap = 0;
            end

            // R3: latch pulse length
            if (adc_ale) ale_run++;
            else if (ale_run > 0) begin
                chk(ale_run == STROBE, "R3 ale width", ale_run, STROBE);
                ale_run = 0;
            end

            // R4: start follows latch directly and has fixed width
            if (adc_start && !st_prev)
                chk(ale_prev && !adc_ale, "R4 start after ale", ale_prev, 1);
            if (adc_start) st_run++;
            else if (st_run > 0) begin
                chk(st_run == STROBE, "R4 start width", st_run, STROBE);
                st_run = 0;
            end

            // R5/R6: output enable gating and width
            if (adc_oe && !oe_prev)
                chk(saw_low && eoc_pin, "R5 oe after eoc low-high", saw_low, 1);
            if (adc_oe) oe_run++;
            else if (oe_run > 0) begin
                chk(oe_run == OE_CYC, "R6 oe width", oe_run, OE_CYC);
                chk(res_valid, "R6 valid after oe", res_valid, 1);
                oe_run = 0;
            end

            // scoreboard
            if (res_valid) begin
                if (exp_q.size() == 0) begin
                    chk(0, "R7 unexpected result", res_data, -1);
                end else begin
                    sample_t e;
                    e = exp_q.pop_front();
                    chk(res_data == e.code, "R6 result code", res_data, e.code);
                    chk(res_chan == e.chan, "R6 result chan", res_chan, e.chan);
                end
                chk(!err_timeout, "R9 valid without err", err_timeout, 0);
            end

            st_prev  = adc_start;
            ale_prev = adc_ale;
            oe_prev  = adc_oe;
            clk_prev = adc_clk;
        end
    end

    task automatic issue(input logic [CHAN_W-1:0] c, input bit expect_ok);
        @(negedge clk);
        req = 1'b1; req_chan = c;
        if (expect_ok) exp_q.push_back('{chan: c, code: code_of(c, pat)});
        @(negedge clk);
        req = 1'b0;
        chk(busy, "R9 busy after accept", busy, 1);
        chk(adc_addr == c, "R3 address driven", adc_addr, c);
    endtask

    task automatic wait_idle();
        while (busy) @(negedge clk);
    endtask

    task automatic fault_case(input int m, input string tag);
        int n;
        mode = m;
        issue(3'd4, 1'b0);
        n = 1;
        while (!err_timeout && n < 3 * TIMEOUT) begin
            @(negedge clk);
            n++;
        end
        chk(err_timeout, tag, err_timeout, 1);
        chk(n >= TIMEOUT && n <= TIMEOUT + 20, "R7 timeout latency", n, TIMEOUT + 13);
        chk(!busy, "R7 idle with error", busy, 0);
        @(negedge clk);
        chk(!err_timeout, "R7 error one cycle", err_timeout, 0);
        mode = 0;
        eoc_pin = 1'b1;
        repeat (CONV + 10) @(negedge clk);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        chk(!adc_ale && !adc_start && !adc_oe && !busy && !res_valid && !err_timeout,
            "R1 reset quiet", {adc_ale, adc_start, adc_oe, busy, res_valid, err_timeout}, 0);
        chk(!adc_clk, "R2 clk low in reset", adc_clk, 0);
        rst = 1'b0;
        repeat (5) @(negedge clk);
        chk(!adc_ale && !adc_start && !adc_oe && !busy, "R1 idle quiet",
            {adc_ale, adc_start, adc_oe, busy}, 0);

        for (int i = 0; i < 8; i++) begin
            issue(CHAN_W'(i), 1'b1);
            wait_idle();
            repeat (3) @(negedge clk);
        end

        pat = 8'hA3;
        issue(3'd7, 1'b1); wait_idle();
        issue(3'd0, 1'b1); wait_idle();
        issue(3'd5, 1'b1); wait_idle();

        // R8: a request while busy leaves no trace
        issue(3'd2, 1'b1);
        repeat (10) @(negedge clk);
        req = 1'b1; req_chan = 3'd6;
        @(negedge clk);
        req = 1'b0;
        chk(adc_addr == 3'd2, "R8 address kept", adc_addr, 2);
        chk(busy, "R8 still busy", busy, 1);
        wait_idle();
        repeat (5) @(negedge clk);
        chk(!busy, "R8 request not replayed", busy, 0);

        fault_case(1, "R7 timeout eoc never low");
        fault_case(2, "R7 timeout eoc never high");

        pat = 8'h3C;
        issue(3'd3, 1'b1); wait_idle();
        repeat (5) @(negedge clk);
        chk(exp_q.size() == 0, "R6 all results seen", exp_q.size(), 0);
        chk(!busy && !adc_oe, "R1 quiet at end", {busy, adc_oe}, 0);

        if (!finished) begin
            finished = 1'b1;
            $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
            $finish;
        end
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!finished) begin
            finished = 1'b1;
            checks++; fails++;
            $display("FAIL watchdog: actual %0d expected %0d", 150000, 0);
            $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
            $finish;
        end
    end
endmodule